// File: doc/BRIEF.md
# DRAM Cycle Timing Generator

This block produces the repeating access timing for a dynamic RAM that a CPU and a display/refresh engine share. A fast master clock is split by a divide-by-two into two half-rate phases of opposite polarity. A four-state strobe ring advances on ticks of the first phase and drives the active-low row and column strobes. A row/column address select moves on ticks of the second phase, so each of its edges falls midway between two strobe edges. Every memory cycle lasts four half-rate periods, which is eight master clocks.

A four-slot sequencer labels each memory cycle. CPU cycles and display/refresh cycles strictly alternate, and successive CPU cycles alternate between read and write. A write strobe reaches the RAM only inside a CPU write slot, only while the CPU is requesting a write, and only while the column strobe is low. A raw reset switch input is synchronised, and the system reset it produces is released only on a second-phase tick. That places the release between active edges of the ring's phase.

All ring and slot activity is expressed as clock enables on the master clock, so the whole block is in one clock domain.

Top module: `dram_cycle_timer`

States, with each state's successor:
- Strobe ring: RING_PRECHARGE (both strobes high) → RING_ROW (row strobe low) → RING_COLUMN (both low) → RING_HOLD (both low) → RING_PRECHARGE. The ring moves one step per first-phase tick.
- Slot sequencer: SLOT_CPU_RD → SLOT_REF_A → SLOT_CPU_WR → SLOT_REF_B → SLOT_CPU_RD. The sequencer moves one step at the end of each memory cycle, which is the ring's RING_HOLD → RING_PRECHARGE transition.

## Requirements
- R1: While `rst_sw_n` is low, `clk8_p` is 0. After release, `clk8_p` inverts on every master clock edge, and `clk8_n` is always its complement.
- R2: While `sys_rst_n` is low, the outputs are held at: `ras_n`=1, `cas_n`=1, `we_n`=1, `col_sel`=0, `cyc_cpu_rd`=1, `cyc_cpu_wr`=0, `cyc_ref`=0.
- R3: `sys_rst_n` goes low as soon as `rst_sw_n` goes low, without waiting for a clock. It rises on the fourth master clock edge after `rst_sw_n` rises, which is an edge where `clk8_p` was 1 before the edge.
- R4: `ras_n` falls on the first master edge after `sys_rst_n` rises. From then on the pattern repeats every 8 master clocks: `ras_n` is low for 6 clocks and high for 2. `cas_n` falls 2 clocks after `ras_n`, stays low for 4 clocks, and rises on the same edge as `ras_n`.
- R5: `col_sel` rises 1 clock after `ras_n` falls, which is 1 clock before `cas_n` falls. It falls 1 clock after `ras_n` rises.
- R6: `cyc_ref` changes only on edges where `ras_n` rises, and it inverts on each of those edges. The first memory cycle after reset is a CPU cycle.
- R7: The first CPU cycle after reset is a read (`cyc_cpu_rd`=1). After that, successive CPU cycles alternate write, read, write, and so on.
- R8: Exactly one of `cyc_cpu_rd`, `cyc_cpu_wr` and `cyc_ref` is 1 at all times.
- R9: `we_n` is 0 exactly when `sys_rst_n`, `cyc_cpu_wr` and `cpu_wr_req` are all 1 and `cas_n` is 0.
- R10: `cpu_wr_req` asserted during a CPU read slot or a refresh slot has no effect: `we_n` stays 1 through those slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (twice the memory timing rate) |
| rst_sw_n | input | 1 | Raw active-low reset switch, asynchronous |
| cpu_wr_req | input | 1 | CPU requests a write in the current CPU write slot |
| clk8_p | output | 1 | Half-rate phase; the ring advances on edges where it is 0 before the edge |
| clk8_n | output | 1 | Complement of `clk8_p`; the select and the reset release move on its ticks |
| sys_rst_n | output | 1 | Synchronised system reset, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| col_sel | output | 1 | Address multiplexer select: 0 = row, 1 = column |
| we_n | output | 1 | RAM write strobe, active low |
| cyc_cpu_rd | output | 1 | Current memory cycle is a CPU read |
| cyc_cpu_wr | output | 1 | Current memory cycle is a CPU write slot |
| cyc_ref | output | 1 | Current memory cycle is a display/refresh cycle |

## Verification
The hardest situation to reach from the ports is a reset switch press that lands in the middle of a memory cycle, or a request that arrives in the wrong slot. In that case the strobes must go high at once, the ring and slot sequencer must restart from a CPU read, and the release must again land on a second-phase tick. The stimulus presses the switch several times at different, deliberately odd offsets into the cycle, including while `cas_n` is low in a write slot with a request pending. It holds `cpu_wr_req` high, toggles it, and drives it from a pseudo-random pattern through read and refresh slots, so that stray write strobes would show. A behavioural model computes every output from the number of edges since release, and the bench compares all outputs against it on every clock.

// File: rtl/dram_timing_pkg.sv
package dram_timing_pkg;

    // Four steps of the strobe ring, in the order they occur
    typedef enum logic [1:0] {
        RING_PRECHARGE = 2'd0,
        RING_ROW       = 2'd1,
        RING_COLUMN    = 2'd2,
        RING_HOLD      = 2'd3
    } ring_state_e;

    // Four memory-cycle slots, in the order they occur
    typedef enum logic [1:0] {
        SLOT_CPU_RD = 2'd0,
        SLOT_REF_A  = 2'd1,
        SLOT_CPU_WR = 2'd2,
        SLOT_REF_B  = 2'd3
    } cycle_slot_e;

    typedef struct packed {
        logic cpu_rd;
        logic cpu_wr;
        logic refresh;
    } slot_qual_t;

endpackage

// File: rtl/phase_divider.sv
module phase_divider (
    input  logic clk,
    input  logic arst_n,
    output logic phase,
    output logic tick_a,
    output logic tick_b
);

    // phase toggles every master edge; 0 before an edge marks a ring tick
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) phase <= 1'b0;
        else         phase <= ~phase;
    end

    assign tick_a = ~phase;
    assign tick_b = phase;

endmodule

// File: rtl/reset_release_sync.sv
module reset_release_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick_b,
    output logic sys_rst_n
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sync_q <= '0;
                else         sync_q <= 1'b1;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) sync_q <= '0;
                else         sync_q <= {sync_q[MSB-1:0], 1'b1};
            end
        end
    endgenerate

    // release only on second-phase ticks: midway between ring ticks
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     sys_rst_n <= 1'b0;
        else if (tick_b) sys_rst_n <= sync_q[MSB];
    end

    assert_release_on_b_R3: assert property (@(posedge clk)
        $rose(sys_rst_n) |-> $past(tick_b));

endmodule

// File: rtl/strobe_ring.sv
module strobe_ring
    import dram_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_a,
    output ring_state_e state,
    output logic        ras_act,
    output logic        cas_act,
    output logic        row_open,
    output logic        cycle_end
);

    ring_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RING_PRECHARGE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (tick_a) begin
            unique case (state)
                RING_PRECHARGE: state_nx = RING_ROW;
                RING_ROW:       state_nx = RING_COLUMN;
                RING_COLUMN:    state_nx = RING_HOLD;
                RING_HOLD:      state_nx = RING_PRECHARGE;
            endcase
        end
    end

    always_comb begin
        ras_act = 1'b0;
        cas_act = 1'b0;
        unique case (state)
            RING_PRECHARGE: begin ras_act = 1'b0; cas_act = 1'b0; end
            RING_ROW:       begin ras_act = 1'b1; cas_act = 1'b0; end
            RING_COLUMN:    begin ras_act = 1'b1; cas_act = 1'b1; end
            RING_HOLD:      begin ras_act = 1'b1; cas_act = 1'b1; end
        endcase
    end

    assign row_open  = (state != RING_PRECHARGE);
    assign cycle_end = tick_a && (state == RING_HOLD);

    assert_ring_moves_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_a |=> $stable(state));

endmodule

// File: rtl/addr_mux_select.sv
module addr_mux_select (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_b,
    input  logic row_open,
    output logic col_sel
);

    // flips on the opposite phase, half a ring step after the row strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      col_sel <= 1'b0;
        else if (tick_b) col_sel <= row_open;
    end

endmodule

// File: rtl/cycle_slot_seq.sv
module cycle_slot_seq
    import dram_timing_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cycle_end,
    output cycle_slot_e slot,
    output slot_qual_t  qual
);

    cycle_slot_e slot_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_CPU_RD;
        else        slot <= slot_nx;
    end

    always_comb begin
        slot_nx = slot;
        if (cycle_end) begin
            unique case (slot)
                SLOT_CPU_RD: slot_nx = SLOT_REF_A;
                SLOT_REF_A:  slot_nx = SLOT_CPU_WR;
                SLOT_CPU_WR: slot_nx = SLOT_REF_B;
                SLOT_REF_B:  slot_nx = SLOT_CPU_RD;
            endcase
        end
    end

    always_comb begin
        qual = '0;
        unique case (slot)
            SLOT_CPU_RD: qual.cpu_rd  = 1'b1;
            SLOT_REF_A:  qual.refresh = 1'b1;
            SLOT_CPU_WR: qual.cpu_wr  = 1'b1;
            SLOT_REF_B:  qual.refresh = 1'b1;
        endcase
    end

endmodule

// File: rtl/dram_cycle_timer.sv
module dram_cycle_timer
    import dram_timing_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_sw_n,
    input  logic cpu_wr_req,
    output logic clk8_p,
    output logic clk8_n,
    output logic sys_rst_n,
    output logic ras_n,
    output logic cas_n,
    output logic col_sel,
    output logic we_n,
    output logic cyc_cpu_rd,
    output logic cyc_cpu_wr,
    output logic cyc_ref
);

    logic        phase;
    logic        tick_a;
    logic        tick_b;
    ring_state_e ring_state;
    logic        ras_act;
    logic        cas_act;
    logic        row_open;
    logic        cycle_end;
    logic        col_q;
    cycle_slot_e slot;
    slot_qual_t  qual;

    phase_divider u_phase (
        .clk    (clk),
        .arst_n (rst_sw_n),
        .phase  (phase),
        .tick_a (tick_a),
        .tick_b (tick_b)
    );

    reset_release_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
        .clk       (clk),
        .arst_n    (rst_sw_n),
        .tick_b    (tick_b),
        .sys_rst_n (sys_rst_n)
    );

    strobe_ring u_ring (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .tick_a    (tick_a),
        .state     (ring_state),
        .ras_act   (ras_act),
        .cas_act   (cas_act),
        .row_open  (row_open),
        .cycle_end (cycle_end)
    );

    addr_mux_select u_mux (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .tick_b   (tick_b),
        .row_open (row_open),
        .col_sel  (col_q)
    );

    cycle_slot_seq u_slot (
        .clk       (clk),
        .rst_n     (sys_rst_n),
        .cycle_end (cycle_end),
        .slot      (slot),
        .qual      (qual)
    );

    // outputs forced to their idle values the moment reset is asserted
    assign clk8_p     = phase;
    assign clk8_n     = ~phase;
    assign ras_n      = ~(ras_act & sys_rst_n);
    assign cas_n      = ~(cas_act & sys_rst_n);
    assign col_sel    = col_q & sys_rst_n;
    assign cyc_cpu_rd = qual.cpu_rd | ~sys_rst_n;
    assign cyc_cpu_wr = qual.cpu_wr & sys_rst_n;
    assign cyc_ref    = qual.refresh & sys_rst_n;
    assign we_n       = ~(cyc_cpu_wr & cpu_wr_req & ~cas_n);

    assert_cas_within_ras_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !cas_n |-> !ras_n);

    assert_col_before_cas_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $fell(cas_n) |-> col_sel);

    assert_row_at_ras_fall_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $fell(ras_n) |-> !col_sel);

    assert_slot_moves_with_ras_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !$stable(cyc_ref) |-> $rose(ras_n));

    assert_one_qualifier_R8: assert property (@(posedge clk)
        $onehot({cyc_cpu_rd, cyc_cpu_wr, cyc_ref}));

    assert_write_only_in_slot_R9: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !we_n |-> (cyc_cpu_wr && !cas_n));

endmodule

// File: tb/tb_dram_cycle_timer.sv
`timescale 1ns/1ps
module tb_dram_cycle_timer;

    logic clk = 1'b0;
    logic rst_sw_n = 1'b0;
    logic cpu_wr_req = 1'b0;
    logic clk8_p, clk8_n, sys_rst_n, ras_n, cas_n, col_sel, we_n;
    logic cyc_cpu_rd, cyc_cpu_wr, cyc_ref;

    int checks = 0;
    int failures = 0;
    int edges = 0;      // master edges since the switch was released
    bit done = 1'b0;
    int lfsr = 32'h1ACE;

    always #4 clk = ~clk;

    dram_cycle_timer dut (
        .clk(clk), .rst_sw_n(rst_sw_n), .cpu_wr_req(cpu_wr_req),
        .clk8_p(clk8_p), .clk8_n(clk8_n), .sys_rst_n(sys_rst_n),
        .ras_n(ras_n), .cas_n(cas_n), .col_sel(col_sel), .we_n(we_n),
        .cyc_cpu_rd(cyc_cpu_rd), .cyc_cpu_wr(cyc_cpu_wr), .cyc_ref(cyc_ref)
    );

    task automatic check(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b edges=%0d t=%0t", tag, name, act, exp, edges, $time);
        end
    endtask

    // ring position after n edges since reset release: 0 pre,1 row,2 col,3 hold
    function automatic int ring_pos(input int n);
        return ((n + 1) / 2) % 4;
    endfunction

    task automatic compare();
        bit run;
        int n, s, m, c;
        logic e_ras, e_cas, e_col, e_ref, e_rd, e_wr, e_we, e_p;
        string tg;
        run = rst_sw_n && edges >= 4;
        e_p = rst_sw_n ? logic'(edges % 2) : 1'b0;
        check("R1", "clk8_p", clk8_p, e_p);
        check("R1", "clk8_n", clk8_n, ~e_p);
        check("R3", "sys_rst_n", sys_rst_n, run);
        if (!run) begin
            check("R2", "ras_n", ras_n, 1'b1);
            check("R2", "cas_n", cas_n, 1'b1);
            check("R2", "col_sel", col_sel, 1'b0);
            check("R2", "we_n", we_n, 1'b1);
            check("R2", "cyc_cpu_rd", cyc_cpu_rd, 1'b1);
            check("R2", "cyc_cpu_wr", cyc_cpu_wr, 1'b0);
            check("R2", "cyc_ref", cyc_ref, 1'b0);
            return;
        end
        n = edges - 4;
        s = ring_pos(n);
        e_ras = (s == 0);
        e_cas = (s < 2);
        m = (n % 2 == 0) ? n - 1 : n - 2;
        e_col = (m >= 1) ? (ring_pos(m) != 0) : 1'b0;
        c = (n + 1) / 8;
        e_ref = logic'(c % 2);
        e_wr = !e_ref && ((c / 2) % 2 == 1);
        e_rd = !e_ref && !e_wr;
        e_we = !(e_wr && cpu_wr_req && !e_cas);
        check("R4", "ras_n", ras_n, e_ras);
        check("R4", "cas_n", cas_n, e_cas);
        check("R5", "col_sel", col_sel, e_col);
        check("R6", "cyc_ref", cyc_ref, e_ref);
        check("R7", "cyc_cpu_rd", cyc_cpu_rd, e_rd);
        check("R7", "cyc_cpu_wr", cyc_cpu_wr, e_wr);
        check("R8", "onehot", logic'((cyc_cpu_rd + cyc_cpu_wr + cyc_ref) == 1), 1'b1);
        tg = (cpu_wr_req && !e_wr) ? "R10" : "R9";
        check(tg, "we_n", we_n, e_we);
    endtask

    task automatic step(input int mode);
        @(posedge clk);
        if (rst_sw_n) edges++;
        @(negedge clk);
        compare();
        unique case (mode)
            0: cpu_wr_req = 1'b0;
            1: cpu_wr_req = 1'b1;
            2: cpu_wr_req = ~cpu_wr_req;
            default: begin
                lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
                cpu_wr_req = lfsr[0];
            end
        endcase
    endtask

    task automatic press_switch(input int hold);
        rst_sw_n = 1'b0;
        #1;
        check("R3", "sys_rst_n async", sys_rst_n, 1'b0);
        check("R2", "ras_n async", ras_n, 1'b1);
        check("R2", "cas_n async", cas_n, 1'b1);
        check("R2", "we_n async", we_n, 1'b1);
        @(negedge clk);
        for (int i = 0; i < hold; i++) step(1);
        rst_sw_n = 1'b1;
        edges = 0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        press_switch(3);
        for (int i = 0; i < 120; i++) step(0);     // R4 R5 R6 R7 idle request
        for (int i = 0; i < 80; i++) step(1);      // R9 R10 request held
        press_switch(2);                            // R2 R3 mid-cycle press
        for (int i = 0; i < 37; i++) step(2);      // R10 toggling
        cpu_wr_req = 1'b1;
        while (!(cyc_cpu_wr && !cas_n)) step(1);   // reach an active write
        press_switch(1);                            // R2 press during a write strobe
        for (int i = 0; i < 400; i++) step(3);     // pseudo-random requests
        press_switch(5);
        for (int i = 0; i < 64; i++) step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule